// File: doc/BRIEF.md
# System Control Block Register Interface

This block is the host-facing register file that sits between a processor bus and the command and receive engines of a network controller. The host writes a command byte and a general pointer register to steer the two engines, reads a status word that shows each engine's state and a set of pending event flags, clears events by writing ones to the acknowledge byte, and masks or forces the single interrupt line through an interrupt-control byte.

On the device side, each engine sees a held command strobe carrying a code and, for codes that need one, the pointer captured from the general register. The engine answers with a one-cycle accept. The matching nibble of the command byte then drops to zero. The host therefore reads the command byte as a busy flag, and writes a new command only after it reads zero. Engines report events as single-cycle pulses, and they drive their current state onto plain inputs that the status word reflects directly.

The host port is a 32-bit word bus with byte enables. Word 0 holds byte offsets 0x00 to 0x03: status low, acknowledge/status high, command, and interrupt control. Word 1 holds offsets 0x04 to 0x07, which is the general pointer. Reads are combinational from the selected word.

Top module: `scb_regs`

## Requirements
- R1: After reset, all event flags are 0, the command byte is 0x00, the interrupt-control byte reads 0x01 (output masked), the general register is 0, both command strobes are low and `irq_o` is low.
- R2: Status bits 5:0 show `ru_state_i` and status bits 7:6 show `cu_state_i` without delay.
- R3: A pulse on `evt_i[k]` sets status bit 11+k (bit 15 command executed, 14 frame received, 13 command unit left active, 12 receiver not ready, 11 management access done) on the next clock edge.
- R4: Writing byte offset 0x01 clears every event flag whose bit is 1 (byte bit n maps to status bit 8+n) and leaves the other flags unchanged. An event arriving in the same cycle as its clear wins, and the flag stays set.
- R5: In the interrupt-control byte, bit 0 is the mask and reads back as written. Writing 1 to bit 1 sets the software-interrupt flag (status bit 10), and bit 1 always reads 0.
- R6: `irq_o` is high exactly when at least one event flag is set and the mask bit is 0.
- R7: The general register at offsets 0x04 to 0x07 is writable byte by byte under the byte enables and reads back its value.
- R8: A legal write to the command byte stores the command-unit code (upper nibble: 1 start, 2 resume, 4 load dump address, 5 dump counters, 6 load base, 7 dump and reset counters) and the receive-unit code (lower nibble: 1 start, 2 resume, 4 abort, 5 load header size, 6 load base). From the next cycle, each nonzero nibble reads back and is presented on its unit's strobe and code outputs.
- R9: Command-unit codes 1, 4 and 6 and receive-unit codes 1, 5 and 6 present the general register value that held at the command write edge. Every other code presents a pointer of 0.
- R10: A strobe and its code stay stable until the unit asserts accept. The nibble and strobe read zero starting at the first cycle after the accepting edge.
- R11: A write to the command byte while either nibble is nonzero is ignored.
- R12: An unsupported code (command unit 3 or 8 to 15, receive unit 3 or 7 to 15) is discarded, and its nibble stays zero. The other nibble of the same write is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 1 | Word select: 0 control word, 1 general pointer |
| host_be | input | 4 | Byte enables for the write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected word |
| cu_state_i | input | 2 | Command-unit state shown in status bits 7:6 |
| ru_state_i | input | 6 | Receive-unit state shown in status bits 5:0 |
| evt_i | input | 5 | Event pulses for status bits 15:11 |
| cu_cmd_valid | output | 1 | Command-unit command pending |
| cu_cmd_code | output | 4 | Pending command-unit code |
| cu_cmd_ptr | output | 32 | Operand pointer for the command unit |
| cu_accept | input | 1 | Command unit takes the pending command |
| ru_cmd_valid | output | 1 | Receive-unit command pending |
| ru_cmd_code | output | 4 | Pending receive-unit code |
| ru_cmd_ptr | output | 32 | Operand pointer for the receive unit |
| ru_accept | input | 1 | Receive unit takes the pending command |
| irq_o | output | 1 | Interrupt request |

## Verification
A lost or stuck event flag appears in the status high byte one cycle after the pulse or acknowledge that should have changed it. The interrupt line shows the same fault in the same cycle, unless the line is masked. A command slot that stays stuck busy keeps the command byte nonzero after accept, and it makes the next command write disappear. A wrongly captured operand appears on the pointer output as soon as the strobe rises. The checks therefore sample each of these outputs exactly one edge after the stimulus, including the cases where set and clear collide and where a write arrives while a command is busy.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int CODE_W  = 4;
    localparam int CODE_N  = 1 << CODE_W;
    localparam int HW_EVT  = 5;
    localparam int EVT_N   = HW_EVT + 1;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;

    // legal and pointer-carrying code sets, one bit per code value
    localparam logic [CODE_N-1:0] CU_LEGAL = 16'h00F6;
    localparam logic [CODE_N-1:0] CU_PTR   = 16'h0052;
    localparam logic [CODE_N-1:0] RU_LEGAL = 16'h0076;
    localparam logic [CODE_N-1:0] RU_PTR   = 16'h0062;

    // byte lanes of the control word
    localparam int LANE_STAT = 0;
    localparam int LANE_ACK  = 1;
    localparam int LANE_CMD  = 2;
    localparam int LANE_IC   = 3;
endpackage

// File: rtl/scb_evt_flags.sv
module scb_evt_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    // set dominates a clear in the same cycle so no event is lost
    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/scb_cmd_slot.sv
module scb_cmd_slot
    import scb_pkg::*;
#(
    parameter int                PTR_W   = 32,
    parameter logic [CODE_N-1:0] LEGAL   = '0,
    parameter logic [CODE_N-1:0] PTR_SET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic              accept_i,
    output logic              busy_o,
    output logic [CODE_W-1:0] code_o,
    output logic [PTR_W-1:0]  ptr_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PTR_W-1:0]  ptr;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  pending;

    assign pending = (slot_q.code != '0);

    always_comb begin
        slot_d = slot_q;
        if (pending) begin
            if (accept_i) begin
                slot_d.code = '0;
                slot_d.ptr  = '0;
            end
        end else if (load_i && LEGAL[code_i]) begin
            slot_d.code = code_i;
            slot_d.ptr  = PTR_SET[code_i] ? ptr_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign busy_o = pending;
    assign code_o = slot_q.code;
    assign ptr_o  = slot_q.ptr;
endmodule

// File: rtl/scb_regs.sv
module scb_regs
    import scb_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [1:0]        cu_state_i,
    input  logic [5:0]        ru_state_i,
    input  logic [4:0]        evt_i,
    output logic              cu_cmd_valid,
    output logic [3:0]        cu_cmd_code,
    output logic [PTR_W-1:0]  cu_cmd_ptr,
    input  logic              cu_accept,
    output logic              ru_cmd_valid,
    output logic [3:0]        ru_cmd_code,
    output logic [PTR_W-1:0]  ru_cmd_ptr,
    input  logic              ru_accept,
    output logic              irq_o
);
    localparam int GEN_BYTES = PTR_W / BYTE_W;

    typedef struct packed {
        logic [PTR_W-1:0] gen;
        logic             mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_ctl, wr_gen;
    logic              ack_wr, cmd_wr, ic_wr;
    logic              cmd_load, cu_busy, ru_busy;
    logic [EVT_N-1:0]  evt_set, evt_clr, evt_flags;
    logic [CODE_W-1:0] cu_code_q, ru_code_q;
    logic              irq_mask;

    assign wr_ctl = host_we && !host_addr;
    assign wr_gen = host_we &&  host_addr;
    assign ack_wr = wr_ctl && host_be[LANE_ACK];
    assign cmd_wr = wr_ctl && host_be[LANE_CMD];
    assign ic_wr  = wr_ctl && host_be[LANE_IC];

    always_comb begin
        ctl_d = ctl_q;
        for (int b = 0; b < GEN_BYTES; b++) begin
            if (wr_gen && host_be[b]) begin
                ctl_d.gen[b*BYTE_W +: BYTE_W] = host_wdata[b*BYTE_W +: BYTE_W];
            end
        end
        if (ic_wr) begin
            ctl_d.mask = host_wdata[LANE_IC*BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.gen  <= '0;
            ctl_q.mask <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_mask = ctl_q.mask;

    // flag index 0 is the software event, 1..5 are the engine events
    assign evt_set = {evt_i, ic_wr && host_wdata[LANE_IC*BYTE_W + 1]};
    assign evt_clr = ack_wr ? host_wdata[LANE_ACK*BYTE_W + 2 +: EVT_N] : '0;

    scb_evt_flags #(.N(EVT_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_set),
        .clr_i   (evt_clr),
        .flags_o (evt_flags)
    );

    assign cmd_load = cmd_wr && !cu_busy && !ru_busy;

    scb_cmd_slot #(.PTR_W(PTR_W), .LEGAL(CU_LEGAL), .PTR_SET(CU_PTR)) u_cu_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cmd_load),
        .code_i   (host_wdata[LANE_CMD*BYTE_W + CODE_W +: CODE_W]),
        .ptr_i    (ctl_q.gen),
        .accept_i (cu_accept),
        .busy_o   (cu_busy),
        .code_o   (cu_code_q),
        .ptr_o    (cu_cmd_ptr)
    );

    scb_cmd_slot #(.PTR_W(PTR_W), .LEGAL(RU_LEGAL), .PTR_SET(RU_PTR)) u_ru_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cmd_load),
        .code_i   (host_wdata[LANE_CMD*BYTE_W +: CODE_W]),
        .ptr_i    (ctl_q.gen),
        .accept_i (ru_accept),
        .busy_o   (ru_busy),
        .code_o   (ru_code_q),
        .ptr_o    (ru_cmd_ptr)
    );

    assign cu_cmd_valid = cu_busy;
    assign cu_cmd_code  = cu_code_q;
    assign ru_cmd_valid = ru_busy;
    assign ru_cmd_code  = ru_code_q;

    assign irq_o = (|evt_flags) && !ctl_q.mask;

    always_comb begin
        if (host_addr) begin
            host_rdata = ctl_q.gen[WORD_W-1:0];
        end else begin
            host_rdata = {7'b0, ctl_q.mask,
                          cu_code_q, ru_code_q,
                          evt_flags, 2'b00,
                          cu_state_i, ru_state_i};
        end
    end
endmodule

// File: rtl/scb_regs_chk.sv
module scb_regs_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       evt_i,
    input logic [5:0]       flags,
    input logic             mask,
    input logic             irq_o,
    input logic             ack_cx_wr,
    input logic             ic_wr,
    input logic             cu_cmd_valid,
    input logic [3:0]       cu_cmd_code,
    input logic [PTR_W-1:0] cu_cmd_ptr,
    input logic             cu_accept,
    input logic             ru_cmd_valid,
    input logic [3:0]       ru_cmd_code,
    input logic             ru_accept
);
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags[5:1] & $past(evt_i)) == $past(evt_i))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cx_wr && !evt_i[4]) |=> !flags[5]); // R4

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq_o); // R6

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[4] && !mask && !ic_wr) |=> irq_o); // R6

    AST_CU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_cmd_valid && !cu_accept) |=> (cu_cmd_valid && $stable(cu_cmd_code))); // R10

    AST_CU_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_cmd_valid && cu_accept) |=> !cu_cmd_valid); // R10

    AST_RU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_cmd_valid && !ru_accept) |=> (ru_cmd_valid && $stable(ru_cmd_code))); // R10

    AST_CU_NOPTR: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_cmd_valid && cu_cmd_code == 4'd2) |-> (cu_cmd_ptr == '0)); // R9

    AST_RU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ru_cmd_valid |-> (ru_cmd_code != 4'd3 && ru_cmd_code < 4'd7)); // R12
endmodule

bind scb_regs scb_regs_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .flags        (evt_flags),
    .mask         (irq_mask),
    .irq_o        (irq_o),
    .ack_cx_wr    (ack_wr && host_wdata[15]),
    .ic_wr        (ic_wr),
    .cu_cmd_valid (cu_cmd_valid),
    .cu_cmd_code  (cu_cmd_code),
    .cu_cmd_ptr   (cu_cmd_ptr),
    .cu_accept    (cu_accept),
    .ru_cmd_valid (ru_cmd_valid),
    .ru_cmd_code  (ru_cmd_code),
    .ru_accept    (ru_accept)
);

// File: tb/scb_regs_tb.sv
module scb_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_addr = 1'b0;
    logic [3:0]  host_be = 4'h0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  cu_state_i = '0;
    logic [5:0]  ru_state_i = '0;
    logic [4:0]  evt_i = '0;
    logic        cu_cmd_valid, ru_cmd_valid;
    logic [3:0]  cu_cmd_code, ru_cmd_code;
    logic [31:0] cu_cmd_ptr, ru_cmd_ptr;
    logic        cu_accept = 1'b0;
    logic        ru_accept = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    scb_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cu_state_i(cu_state_i), .ru_state_i(ru_state_i), .evt_i(evt_i),
        .cu_cmd_valid(cu_cmd_valid), .cu_cmd_code(cu_cmd_code),
        .cu_cmd_ptr(cu_cmd_ptr), .cu_accept(cu_accept),
        .ru_cmd_valid(ru_cmd_valid), .ru_cmd_code(ru_cmd_code),
        .ru_cmd_ptr(ru_cmd_ptr), .ru_accept(ru_accept),
        .irq_o(irq_o)
    );

    // {evt[4:0], ack_en, ack[7:0], ic_en, ic[7:0], exp_hi[7:0], exp_irq}
    localparam int NV = 11;
    localparam logic [31:0] VEC [NV] = '{
        {5'b10000, 1'b0, 8'h00, 1'b0, 8'h00, 8'h80, 1'b0},
        {5'b00000, 1'b0, 8'h00, 1'b1, 8'h00, 8'h80, 1'b1},
        {5'b00000, 1'b1, 8'h80, 1'b0, 8'h00, 8'h00, 1'b0},
        {5'b01001, 1'b0, 8'h00, 1'b0, 8'h00, 8'h48, 1'b1},
        {5'b00001, 1'b1, 8'h08, 1'b0, 8'h00, 8'h48, 1'b1},
        {5'b00000, 1'b1, 8'h40, 1'b0, 8'h00, 8'h08, 1'b1},
        {5'b00000, 1'b0, 8'h00, 1'b1, 8'h01, 8'h08, 1'b0},
        {5'b00000, 1'b0, 8'h00, 1'b1, 8'h02, 8'h0C, 1'b1},
        {5'b00000, 1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0},
        {5'b11111, 1'b0, 8'h00, 1'b1, 8'h03, 8'hFC, 1'b0},
        {5'b00000, 1'b1, 8'hFC, 1'b1, 8'h00, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_be = be; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_be = 4'h0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic pulse_accept(input logic cu, input logic ru);
        @(negedge clk);
        cu_accept = cu; ru_accept = ru;
        @(negedge clk);
        cu_accept = 1'b0; ru_accept = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, r); chk("R1 control word", r, 32'h0100_0000);
        rd(1'b1, r); chk("R1 general", r, 32'h0);
        chk("R1 strobes/irq", {31'b0, cu_cmd_valid | ru_cmd_valid | irq_o}, 32'h0);

        // R2 state passthrough
        cu_state_i = 2'b10; ru_state_i = 6'h10;
        rd(1'b0, r); chk("R2 status low", {24'b0, r[7:0]}, 32'h90);
        cu_state_i = 2'b01; ru_state_i = 6'h08;
        rd(1'b0, r); chk("R2 status low", {24'b0, r[7:0]}, 32'h48);

        // R3 R4 R5 R6 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            @(negedge clk);
            evt_i      = v[31:27];
            host_we    = v[26] | v[17];
            host_addr  = 1'b0;
            host_be    = {v[17], 1'b0, v[26], 1'b0};
            host_wdata = {v[16:9], 8'h00, v[25:18], 8'h00};
            @(negedge clk);
            host_we = 1'b0; host_be = 4'h0; evt_i = '0;
            rd(1'b0, r);
            chk("R3/R4/R5 flags", {24'b0, r[15:8]}, {24'b0, v[8:1]});
            chk("R6 irq", {31'b0, irq_o}, {31'b0, v[0]});
            if (i == 7) chk("R5 ic readback", {24'b0, r[31:24]}, 32'h0);
        end

        // R7 general register byte lanes
        wr(1'b1, 4'hF, 32'hDEAD_BEEF);
        rd(1'b1, r); chk("R7 full write", r, 32'hDEAD_BEEF);
        wr(1'b1, 4'b0010, 32'h1234_5678);
        rd(1'b1, r); chk("R7 byte write", r, 32'hDEAD_56EF);

        // R8 R9 pointer commands
        wr(1'b0, 4'b0100, 32'h0016_0000);
        rd(1'b0, r); chk("R8 cmd readback", {24'b0, r[23:16]}, 32'h16);
        chk("R8 cu strobe", {27'b0, cu_cmd_valid, cu_cmd_code}, {27'b0, 1'b1, 4'h1});
        chk("R8 ru strobe", {27'b0, ru_cmd_valid, ru_cmd_code}, {27'b0, 1'b1, 4'h6});
        chk("R9 cu ptr", cu_cmd_ptr, 32'hDEAD_56EF);
        chk("R9 ru ptr", ru_cmd_ptr, 32'hDEAD_56EF);

        // R11 write while busy ignored
        wr(1'b0, 4'b0100, 32'h0020_0000);
        rd(1'b0, r); chk("R11 busy write", {24'b0, r[23:16]}, 32'h16);

        // R10 accept handshake
        pulse_accept(1'b1, 1'b0);
        rd(1'b0, r); chk("R10 cu cleared", {24'b0, r[23:16]}, 32'h06);
        chk("R10 valids", {30'b0, cu_cmd_valid, ru_cmd_valid}, 32'h1);
        pulse_accept(1'b0, 1'b1);
        rd(1'b0, r); chk("R10 ru cleared", {24'b0, r[23:16]}, 32'h00);

        // R9 codes without operand
        wr(1'b0, 4'b0100, 32'h0022_0000);
        chk("R9 resume ptrs", cu_cmd_ptr | ru_cmd_ptr, 32'h0);
        chk("R8 resume codes", {24'b0, cu_cmd_code, ru_cmd_code}, 32'h22);
        pulse_accept(1'b1, 1'b1);
        chk("R10 both cleared", {30'b0, cu_cmd_valid, ru_cmd_valid}, 32'h0);

        // R12 unsupported codes
        wr(1'b0, 4'b0100, 32'h0033_0000);
        rd(1'b0, r); chk("R12 both illegal", {24'b0, r[23:16]}, 32'h00);
        wr(1'b0, 4'b0100, 32'h0083_0000);
        rd(1'b0, r); chk("R12 cu 8 illegal", {24'b0, r[23:16]}, 32'h00);
        wr(1'b0, 4'b0100, 32'h0047_0000);
        rd(1'b0, r); chk("R12 ru 7 dropped", {24'b0, r[23:16]}, 32'h40);
        chk("R9 load dump ptr", cu_cmd_ptr, 32'hDEAD_56EF);
        chk("R12 ru idle", {31'b0, ru_cmd_valid}, 32'h0);
        pulse_accept(1'b1, 1'b0);
        rd(1'b0, r); chk("R10 final idle", {24'b0, r[23:16]}, 32'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule